// File: doc/BRIEF.md
# Training-Based Sampling Phase Selector

This block sits behind an oversampling front end on one serial lane. On every bit period it receives one sample bit per internally shifted clock phase, and it routes exactly one of those samples to its serial output. The phase it routes is chosen in one of two ways. In the two training modes, a transmitter sends a known training word while the calibration input is held high. The block gathers each phase's samples into a word of its own, compares every word with the expected pattern at each word boundary, and commits the best phase when calibration ends. In the preset mode, no training takes place and a configured phase code is applied directly.

The single-bit mode uses five phases spaced a quarter bit apart. Index 2 is the nominal 0° phase and indices 0..4 span -180° to +180°. Its training word keeps word alignment because the word counter restarts at the start of calibration. The multi-bit mode uses eight phases, so the window reaches into the neighbouring bit. It trains on an alternating pattern and corrects skew only, not word boundaries.

Top module: `phase_pick_sampler`

## Requirements
- R1: Out of reset `phase_sel` is 2 (the 0° phase), `locked` is 0 and `cal_fail` is 0.
- R2: `data_out` always equals `samples[phase_sel]`, combinationally.
- R3: In a training mode (`mode` 0 = single-bit, 1 = multi-bit), a rising clock edge that sees `cal_en` high while not calibrating starts calibration and restarts the word counter. The first training bit is captured on the next edge. A word is `deser_factor` bits long and the first bit received is its most significant bit. `deser_factor` is 4..10 in single-bit mode and 2..10 in multi-bit mode.
- R4: Single-bit training expects ceil(F/2) zeros followed by floor(F/2) ones, for F = `deser_factor`. Only phases 0..4 may qualify.
- R5: Multi-bit training accepts an alternating word of either polarity on any of the eight phases.
- R6: A phase qualifies only after its word matches at three consecutive word boundaries. A mismatching word restarts that phase's count.
- R7: When several phases qualify, the selected index is floor((lo+hi)/2). Here lo is the lowest qualifying index and hi is the top of the contiguous run that starts at lo.
- R8: On the edge that sees `cal_en` low during calibration, a qualifying phase is latched, with `locked`=1 and `cal_fail`=0. If no phase qualifies, `phase_sel` and `locked` keep their values and `cal_fail` becomes 1.
- R9: `phase_sel` does not change while calibration is running.
- R10: In preset mode (`mode[1]`=1), `phase_sel` takes `preset_code` one edge later. Codes 0..4 map to -180°, -90°, 0°, 90° and 180°, and codes 5..7 act as 4. In this mode `locked`=1, `cal_fail`=0 and `cal_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_en | input | 1 | Calibration window, high while training is sent |
| mode | input | 2 | 0 single-bit, 1 multi-bit, 2 or 3 preset |
| preset_code | input | 3 | Phase code for preset mode |
| deser_factor | input | 4 | Word length used for training |
| samples | input | 8 | One sample per phase for the current bit |
| data_out | output | 1 | Sample of the selected phase |
| phase_sel | output | 3 | Selected phase index |
| locked | output | 1 | A phase has been committed |
| cal_fail | output | 1 | Last calibration found no qualifying phase |

## Verification
The checker assumes that `mode` stays fixed while calibration is running and that `deser_factor` stays within the range allowed for the mode. The bench changes `mode` and the factor only while `cal_en` is low, and it uses only legal factors. The checker also takes each training word to start on the edge that follows calibration entry. The bench therefore drives the first training bit right after raising `cal_en`, and it gives each phase either the true training stream or a constant zero.

// File: rtl/psel_pkg.sv
// Package: shared mode encoding and phase-code helper for the phase selector.
// Assumes the preset code addresses the five quarter-bit phases.
package psel_pkg;
    typedef enum logic [1:0] {
        PM_SINGLE    = 2'd0,
        PM_MULTI     = 2'd1,
        PM_PRESET    = 2'd2,
        PM_PRESET_B  = 2'd3
    } psel_mode_t;

    // Clamp a preset code to the highest single-bit phase index.
    function automatic logic [2:0] clamp_code(input logic [2:0] code, input int top);
        return (int'(code) > top) ? 3'(top) : code;
    endfunction
endpackage

// File: rtl/psel_lane.sv
// Module: one phase lane. It shifts that phase's samples into a word and
// counts consecutive word boundaries at which the word matches the expected
// pattern. Assumes exp_word and mask are stable for the whole calibration.
module psel_lane #(
    parameter int MAX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             word_end,
    input  logic             sample,
    input  logic [MAX_W-1:0] exp_word,
    input  logic [MAX_W-1:0] mask,
    input  logic             accept_inv,
    output logic             qual
);
    logic [MAX_W-2:0] word;
    logic [MAX_W-1:0] nxt;
    logic [1:0]       streak;
    logic             hit;

    // Next word value and match against the pattern or, optionally, its inverse.
    always_comb begin
        nxt = {word, sample};
        hit = (((nxt ^ exp_word) & mask) == '0) ||
              (accept_inv && (((nxt ^ ~exp_word) & mask) == '0));
    end

    // Shift register plus saturating count of consecutive matching words.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word   <= '0;
            streak <= '0;
        end else if (shift_en) begin
            word <= nxt[MAX_W-2:0];
            if (word_end)
                streak <= hit ? ((streak == 2'd3) ? 2'd3 : streak + 2'd1) : 2'd0;
        end
    end

    assign qual = (streak == 2'd3);
endmodule

// File: rtl/psel_pick.sv
// Module: picks the centre of the lowest contiguous run of qualifying phases.
// Assumes qual is already masked to the lanes legal in the current mode.
module psel_pick #(
    parameter int NPH = 8,
    parameter int IW  = 3
) (
    input  logic [NPH-1:0] qual,
    output logic           found,
    output logic [IW-1:0]  mid
);
    int  lo, hi;
    logic seen, run;

    // Scan upward: first set bit opens the run, first clear bit after it closes it.
    always_comb begin
        lo = 0; hi = 0; seen = 1'b0; run = 1'b0;
        for (int i = 0; i < NPH; i++) begin
            if (qual[i]) begin
                if (!seen) begin
                    lo = i; hi = i; seen = 1'b1; run = 1'b1;
                end else if (run) begin
                    hi = i;
                end
            end else begin
                run = 1'b0;
            end
        end
        found = seen;
        mid   = IW'((lo + hi) / 2);
    end
endmodule

// File: rtl/phase_pick_sampler.sv
// Module: top of the training-based sampling phase selector. It runs the
// calibration window, builds the expected word for the active mode, owns the
// selected phase register and muxes the chosen sample out.
// Assumes mode and deser_factor are steady while calibration runs.
module phase_pick_sampler
    import psel_pkg::*;
#(
    parameter int MAX_W      = 10,
    parameter int NPH        = 8,
    parameter int NPH_SINGLE = 5,
    parameter int FW         = $clog2(MAX_W + 1),
    parameter int IW         = $clog2(NPH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cal_en,
    input  logic [1:0]     mode,
    input  logic [2:0]     preset_code,
    input  logic [FW-1:0]  deser_factor,
    input  logic [NPH-1:0] samples,
    output logic           data_out,
    output logic [IW-1:0]  phase_sel,
    output logic           locked,
    output logic           cal_fail
);
    localparam int CENTER = NPH_SINGLE / 2;

    psel_mode_t       md;
    logic             is_preset, is_multi;
    logic             cal_active;
    logic [FW-1:0]    bitcnt;
    logic             word_end, start, shift_en;
    logic [MAX_W-1:0] mask, exp_word;
    logic [NPH-1:0]   qual, lane_en;
    logic             found;
    logic [IW-1:0]    mid;

    assign md        = psel_mode_t'(mode);
    assign is_preset = (md == PM_PRESET) || (md == PM_PRESET_B);
    assign is_multi  = (md == PM_MULTI);
    assign start     = !is_preset && !cal_active && cal_en;
    assign shift_en  = !is_preset && cal_active && cal_en;
    assign word_end  = (bitcnt == deser_factor - FW'(1));

    // Expected word and valid-bit mask for the current factor and mode.
    always_comb begin
        for (int i = 0; i < MAX_W; i++) begin
            mask[i]     = (i < int'(deser_factor));
            exp_word[i] = is_multi ? ((i % 2) == 1) : (i < int'(deser_factor) / 2);
        end
    end

    // One lane per phase; lanes above the single-bit set are disabled there.
    for (genvar g = 0; g < NPH; g++) begin : g_lane
        psel_lane #(.MAX_W(MAX_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .clear(start), .shift_en(shift_en),
            .word_end(word_end), .sample(samples[g]), .exp_word(exp_word),
            .mask(mask), .accept_inv(is_multi), .qual(qual[g])
        );
        assign lane_en[g] = is_multi || (g < NPH_SINGLE);
    end

    psel_pick #(.NPH(NPH), .IW(IW)) u_pick (
        .qual(qual & lane_en), .found(found), .mid(mid)
    );

    // Calibration window, word counter and committed phase state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_active <= 1'b0;
            bitcnt     <= '0;
            phase_sel  <= IW'(CENTER);
            locked     <= 1'b0;
            cal_fail   <= 1'b0;
        end else if (is_preset) begin
            cal_active <= 1'b0;
            phase_sel  <= IW'(clamp_code(preset_code, NPH_SINGLE - 1));
            locked     <= 1'b1;
            cal_fail   <= 1'b0;
        end else if (!cal_active) begin
            if (cal_en) begin
                cal_active <= 1'b1;
                bitcnt     <= '0;
            end
        end else if (!cal_en) begin
            cal_active <= 1'b0;
            if (found) begin
                phase_sel <= mid;
                locked    <= 1'b1;
                cal_fail  <= 1'b0;
            end else begin
                cal_fail  <= 1'b1;
            end
        end else begin
            bitcnt <= word_end ? '0 : bitcnt + FW'(1);
        end
    end

    // Serial output: the sample of the committed phase.
    assign data_out = samples[phase_sel];
endmodule

// File: rtl/psel_chk.sv
// Checker: temporal properties of the phase selector, bound to the top.
// Assumes the inputs keep to the limits listed in the brief.
module psel_chk #(
    parameter int MAX_W = 10,
    parameter int FW    = 4,
    parameter int IW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cal_en,
    input logic [1:0]    mode,
    input logic [2:0]    preset_code,
    input logic [FW-1:0] deser_factor,
    input logic [IW-1:0] phase_sel,
    input logic          locked,
    input logic          cal_fail,
    input logic          cal_active
);
    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_sel) |-> (($past(cal_active) && !$past(cal_en)) || $past(mode[1])));

    // R10
    preset_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |=> (int'(phase_sel) == ((int'($past(preset_code)) > 4) ? 4 : int'($past(preset_code)))));

    // R10
    preset_nocal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |=> !cal_active && !cal_fail && locked);

    // R8
    fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_fail) |-> ($stable(phase_sel) && $stable(locked)));

    // R8
    lock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (($past(cal_active) && !$past(cal_en)) || $past(mode[1])));

    // R3
    mode_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_active && cal_en) |-> $stable(mode));

    // R3
    factor_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> ((int'(deser_factor) >= (mode[0] ? 2 : 4)) && (int'(deser_factor) <= MAX_W)));
endmodule

bind phase_pick_sampler psel_chk #(.MAX_W(MAX_W), .FW(FW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .mode(mode),
    .preset_code(preset_code), .deser_factor(deser_factor),
    .phase_sel(phase_sel), .locked(locked), .cal_fail(cal_fail),
    .cal_active(cal_active)
);

// File: tb/sim_phase_pick_sampler.sv
module sim_phase_pick_sampler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [2:0] preset_code = 3'd0;
    logic [3:0] deser_factor = 4'd8;
    logic [7:0] samples = 8'd0;
    logic       data_out;
    logic [2:0] phase_sel;
    logic       locked, cal_fail;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phase_pick_sampler u0 (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .mode(mode),
        .preset_code(preset_code), .deser_factor(deser_factor),
        .samples(samples), .data_out(data_out), .phase_sel(phase_sel),
        .locked(locked), .cal_fail(cal_fail)
    );

    // {mode, alt pattern, inverted, factor, good phases, expected phase, expected fail}
    localparam logic [19:0] VEC [0:7] = '{
        {2'd0, 1'b0, 1'b0, 4'd10, 8'b0000_0110, 3'd1, 1'b0},  // R4 R7
        {2'd0, 1'b0, 1'b0, 4'd8,  8'b0001_1000, 3'd3, 1'b0},  // R4 R7
        {2'd0, 1'b0, 1'b0, 4'd4,  8'b0000_0001, 3'd0, 1'b0},  // R4
        {2'd0, 1'b0, 1'b0, 4'd7,  8'b1110_0000, 3'd0, 1'b1},  // R4 R8: phases 5..7 not legal
        {2'd1, 1'b1, 1'b0, 4'd8,  8'b1111_0000, 3'd5, 1'b0},  // R5 R7
        {2'd1, 1'b1, 1'b1, 4'd10, 8'b0010_0110, 3'd1, 1'b0},  // R5 R7 inverse polarity
        {2'd1, 1'b1, 1'b0, 4'd2,  8'b1000_0000, 3'd7, 1'b0},  // R5
        {2'd0, 1'b0, 1'b0, 4'd9,  8'b0001_1111, 3'd2, 1'b0}   // R4 R7
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one calibration; called and returns at a falling edge.
    task automatic run_cal(input logic [1:0] md, input logic alt, input logic inv,
                           input int f, input logic [7:0] good, input int nwords,
                           input int bad);
        logic [2:0] prior;
        prior = phase_sel;
        mode = md;
        deser_factor = 4'(f);
        cal_en = 1'b1;
        @(negedge clk);
        for (int w = 0; w < nwords; w++) begin
            for (int b = 0; b < f; b++) begin
                logic bitv;
                if (alt) bitv = logic'(((f - 1 - b) % 2) == 1) ^ inv;
                else     bitv = (b >= f - f / 2);
                samples = (w == bad) ? 8'd0 : (bitv ? good : 8'd0);
                @(negedge clk);
            end
        end
        chk(phase_sel == prior, "R9", int'(phase_sel), int'(prior));
        cal_en = 1'b0;
        samples = 8'd0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(phase_sel == 3'd2, "R1", int'(phase_sel), 2);
        chk(locked == 1'b0, "R1", int'(locked), 0);
        chk(cal_fail == 1'b0, "R1", int'(cal_fail), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 output follows the selected phase
        samples = 8'b0000_0100;
        #1 chk(data_out == 1'b1, "R2", int'(data_out), 1);
        samples = 8'b1111_1011;
        #1 chk(data_out == 1'b0, "R2", int'(data_out), 0);
        samples = 8'd0;
        @(negedge clk);

        // Vector table walk: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            logic [19:0] e;
            e = VEC[v];
            run_cal(e[19:18], e[17], e[16], int'(e[15:12]), e[11:4], 3, -1);
            chk(phase_sel == e[3:1], "R7", int'(phase_sel), int'(e[3:1]));
            chk(cal_fail == e[0], "R8", int'(cal_fail), int'(e[0]));
            chk(locked == 1'b1, "R8", int'(locked), 1);
        end

        // R2 after selecting phase 2
        samples = 8'b0000_0100;
        #1 chk(data_out == 1'b1, "R2", int'(data_out), 1);
        samples = 8'd0;
        @(negedge clk);

        // R6 only two words: no phase qualifies, selection kept
        run_cal(2'd0, 1'b0, 1'b0, 8, 8'b0001_1111, 2, -1);
        chk(cal_fail == 1'b1, "R6", int'(cal_fail), 1);
        chk(phase_sel == 3'd2, "R6", int'(phase_sel), 2);

        // R6 a bad word splits the run into 2 + 2
        run_cal(2'd0, 1'b0, 1'b0, 6, 8'b0000_0001, 5, 2);
        chk(cal_fail == 1'b1, "R6", int'(cal_fail), 1);
        chk(phase_sel == 3'd2, "R6", int'(phase_sel), 2);

        // R6 a bad word followed by three good ones qualifies
        run_cal(2'd0, 1'b0, 1'b0, 6, 8'b0000_0001, 6, 2);
        chk(cal_fail == 1'b0, "R6", int'(cal_fail), 0);
        chk(phase_sel == 3'd0, "R6", int'(phase_sel), 0);

        // R4 alternating pattern is rejected in single-bit mode
        run_cal(2'd0, 1'b1, 1'b0, 8, 8'b0001_1110, 3, -1);
        chk(cal_fail == 1'b1, "R4", int'(cal_fail), 1);
        chk(phase_sel == 3'd0, "R4", int'(phase_sel), 0);

        // R10 preset mode
        mode = 2'd2;
        preset_code = 3'd4;
        @(negedge clk);
        chk(phase_sel == 3'd4, "R10", int'(phase_sel), 4);
        chk(locked == 1'b1 && cal_fail == 1'b0, "R10", int'(cal_fail), 0);
        preset_code = 3'd6;
        @(negedge clk);
        chk(phase_sel == 3'd4, "R10", int'(phase_sel), 4);
        // R10 calibration request ignored in preset mode
        preset_code = 3'd1;
        cal_en = 1'b1;
        samples = 8'hFF;
        repeat (12) @(negedge clk);
        cal_en = 1'b0;
        samples = 8'd0;
        @(negedge clk);
        chk(phase_sel == 3'd1, "R10", int'(phase_sel), 1);
        chk(cal_fail == 1'b0, "R10", int'(cal_fail), 0);
        samples = 8'b0000_0010;
        #1 chk(data_out == 1'b1, "R2", int'(data_out), 1);
        samples = 8'd0;
        mode = 2'd0;
        @(negedge clk);

        // R8 successful recalibration after leaving preset
        run_cal(2'd0, 1'b0, 1'b0, 10, 8'b0001_1000, 4, -1);
        chk(phase_sel == 3'd3, "R8", int'(phase_sel), 3);
        chk(cal_fail == 1'b0, "R8", int'(cal_fail), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule